// File: doc/BRIEF.md
# Programmable High/Low Pulse Shaper

This block produces a repeating waveform on a single output. The number of input clock cycles spent high and the number spent low are each set by a 4-bit code. It shapes or delays a clock-rate output when the digital delay path is on. Code 0 stands for sixteen cycles. Codes 2 to 15 stand for that many cycles. Code 1 is reserved, and the block refuses to run while either field holds it.

While enable is low, the output sits low and the internal counter is cleared. When enable goes high and both codes are legal, the waveform starts with a low phase and then alternates. The length of each phase is latched when that phase begins. A code that changes partway through a phase therefore only takes effect at the next phase of the same kind. Reserved codes raise a flag at once and force the output low. Once the codes are fixed, the waveform starts again from a fresh low phase.

Top module: `ddly_pulse_gen`

## Requirements
- R1: While reset is asserted and after it is released with enable low, pulseOut is 0. With legal codes on both fields, badCode is 0.
- R2: If enable is sampled low at a rising edge, pulseOut is 0 after that edge and stays 0 while enable stays low. Each restart begins with a low phase.
- R3: Each high phase of pulseOut lasts L(highCode) cycles. L(0)=16, and L(n)=n for n from 2 to 15.
- R4: Each low phase of pulseOut lasts L(lowCode) cycles, using the same mapping as R3.
- R5: When either field equals 1, badCode is 1 in the same cycle, combinationally. pulseOut is 0 after every rising edge at which a field equal to 1 is sampled.
- R6: When a reserved code is replaced by a legal one while enable stays high, the waveform restarts with a full low phase of L(lowCode) cycles, then a high phase.
- R7: The length of a phase is taken from its code at the edge where that phase begins. A code change during a phase leaves that phase's length unchanged and applies to the next phase of that kind.
- R8: After the rising edge that first samples enable high with legal codes, pulseOut stays low for exactly L(lowCode) cycles before its first high cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; every count is in cycles of this clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the shaper when high; holds pulseOut low and clears the counter when low |
| highCode | input | 4 | High-phase length code (0 means 16, 1 is reserved, 2 to 15 are literal) |
| lowCode | input | 4 | Low-phase length code (same encoding as highCode) |
| pulseOut | output | 1 | Shaped output waveform |
| badCode | output | 1 | High when either code field holds the reserved value 1 |

## Verification
The hardest case to reach is a code change that lands partway through a running phase. That phase must finish with its old length, and the new length must apply only to the next phase of the same kind. The bench reaches this by watching pulseOut on falling edges. On the first sampled high cycle it rewrites highCode, and it then measures the rest of that high phase, the following low phase and the next high phase. A second awkward case is recovery from a reserved code while enable stays high. The bench forces code 1 mid-waveform, checks that the output stays flat, then corrects the code and times the fresh low phase.

// File: rtl/ddly_pkg.sv
package ddly_pkg;
  localparam int DefCodeW = 4;
  localparam int DefRstCode = 5;
  localparam int DefRsvCode = 1;

  typedef struct packed {
    logic clear;
    logic start;
    logic toggle;
    logic count;
  } dlyStrobe_t;
endpackage

// File: rtl/ddly_datapath.sv
module ddly_datapath
  import ddly_pkg::*;
#(
  parameter int CODE_W   = DefCodeW,
  parameter int RST_CODE = DefRstCode,
  parameter int RSV_CODE = DefRsvCode
) (
  input  logic              clk,
  input  logic              rstN,
  input  dlyStrobe_t        stb,
  input  logic              phaseHigh,
  input  logic [CODE_W-1:0] highCode,
  input  logic [CODE_W-1:0] lowCode,
  output logic              phaseDone,
  output logic              codeBad
);
  localparam int LEN_W = CODE_W + 1;
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(1) << CODE_W;
  localparam logic [LEN_W-1:0] RST_LEN  = LEN_W'(RST_CODE);
  localparam logic [CODE_W-1:0] RSV     = CODE_W'(RSV_CODE);

  logic [LEN_W-1:0] lenHigh, lenLow, cnt, curLen;
  logic [LEN_W-1:0] decHigh, decLow;

  function automatic logic [LEN_W-1:0] decodeLen(input logic [CODE_W-1:0] c);
    return (c == '0) ? FULL_LEN : {1'b0, c};
  endfunction

  always_comb begin
    decHigh = decodeLen(highCode);
    decLow  = decodeLen(lowCode);
    codeBad = (highCode == RSV) || (lowCode == RSV);
    curLen  = phaseHigh ? lenHigh : lenLow;
    phaseDone = (cnt == curLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenHigh <= RST_LEN;
      lenLow  <= RST_LEN;
      cnt     <= '0;
    end else if (stb.clear) begin
      cnt <= '0;
    end else if (stb.start) begin
      cnt     <= LEN_W'(1);
      lenHigh <= decHigh;
      lenLow  <= decLow;
    end else if (stb.toggle) begin
      cnt <= LEN_W'(1);
      if (phaseHigh) lenLow  <= decLow;
      else           lenHigh <= decHigh;
    end else if (stb.count) begin
      cnt <= cnt + LEN_W'(1);
    end
  end

  // R7
  len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.start || stb.toggle) |=> ($stable(lenHigh) && $stable(lenLow)));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= curLen);

  // R8
  start_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> (cnt == LEN_W'(1)));
endmodule

// File: rtl/ddly_ctrl.sv
module ddly_ctrl
  import ddly_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       codeBad,
  input  logic       phaseDone,
  output dlyStrobe_t stb,
  output logic       phaseHigh
);
  logic running;
  logic haltReq;

  always_comb begin
    haltReq = !enable || codeBad;
    stb = '0;
    if (haltReq)         stb.clear  = 1'b1;
    else if (!running)   stb.start  = 1'b1;
    else if (phaseDone)  stb.toggle = 1'b1;
    else                 stb.count  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      phaseHigh <= 1'b0;
    end else if (stb.clear) begin
      running   <= 1'b0;
      phaseHigh <= 1'b0;
    end else if (stb.start) begin
      running   <= 1'b1;
      phaseHigh <= 1'b0;
    end else if (stb.toggle) begin
      phaseHigh <= ~phaseHigh;
    end
  end

  // R2
  off_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !phaseHigh);

  // R5
  bad_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeBad |=> !phaseHigh);

  // R3
  rise_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phaseHigh) |-> $past(phaseDone && running));

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !phaseDone && enable && !codeBad) |=> $stable(phaseHigh));
endmodule

// File: rtl/ddly_pulse_gen.sv
module ddly_pulse_gen
  import ddly_pkg::*;
#(
  parameter int CODE_W   = DefCodeW,
  parameter int RST_CODE = DefRstCode,
  parameter int RSV_CODE = DefRsvCode
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CODE_W-1:0] highCode,
  input  logic [CODE_W-1:0] lowCode,
  output logic              pulseOut,
  output logic              badCode
);
  dlyStrobe_t stb;
  logic phaseHigh, phaseDone, codeBad;

  ddly_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .codeBad   (codeBad),
    .phaseDone (phaseDone),
    .stb       (stb),
    .phaseHigh (phaseHigh)
  );

  ddly_datapath #(
    .CODE_W   (CODE_W),
    .RST_CODE (RST_CODE),
    .RSV_CODE (RSV_CODE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .phaseHigh (phaseHigh),
    .highCode  (highCode),
    .lowCode   (lowCode),
    .phaseDone (phaseDone),
    .codeBad   (codeBad)
  );

  assign pulseOut = phaseHigh;
  assign badCode  = codeBad;
endmodule

// File: tb/tb_ddly_pulse_gen.sv
module tb_ddly_pulse_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [3:0] highCode = 4'd5;
  logic [3:0] lowCode = 4'd5;
  logic pulseOut, badCode;

  int vecs = 0;
  int errs = 0;

  always #2 clk = ~clk;

  ddly_pulse_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .highCode(highCode), .lowCode(lowCode),
    .pulseOut(pulseOut), .badCode(badCode)
  );

  localparam int TBL_N = 6;
  localparam int tblH[TBL_N]    = '{0, 2, 15, 2, 5, 0};
  localparam int tblL[TBL_N]    = '{0, 2, 2, 15, 5, 3};
  localparam int tblExpH[TBL_N] = '{16, 2, 15, 2, 5, 16};
  localparam int tblExpL[TBL_N] = '{16, 2, 2, 15, 5, 3};

  function automatic int expLen(input int c);
    return (c == 0) ? 16 : c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count low cycles before the first high, then one high run and one low run.
  task automatic measure(output int fl, output int hi, output int lo);
    fl = 0; hi = 0; lo = 0;
    @(negedge clk);
    while (!pulseOut && fl < 40) begin fl++; @(negedge clk); end
    while (pulseOut && hi < 40) begin hi++; @(negedge clk); end
    while (!pulseOut && lo < 40) begin lo++; @(negedge clk); end
  endtask

  task automatic runPair(input int h, input int l, output int fl, output int hi, output int lo);
    @(negedge clk);
    enable = 1'b0; highCode = 4'(h); lowCode = 4'(l);
    @(negedge clk);
    enable = 1'b1;
    measure(fl, hi, lo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int fl, hi, lo, cnt;
    // R1 reset state
    #1;
    check("R1 pulse in reset", int'(pulseOut), 0);
    check("R1 bad in reset", int'(badCode), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pulse after reset", int'(pulseOut), 0);

    // Table of directed pairs: R3, R4, R8
    for (int i = 0; i < TBL_N; i++) begin
      runPair(tblH[i], tblL[i], fl, hi, lo);
      check("R8 first low", fl, tblExpL[i]);
      check("R3 high len", hi, tblExpH[i]);
      check("R4 low len", lo, tblExpL[i]);
    end

    // Every legal code pair
    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 16; l++) begin
        if (h != 1 && l != 1) begin
          runPair(h, l, fl, hi, lo);
          check("R8 sweep first low", fl, expLen(l));
          check("R3 sweep high", hi, expLen(h));
          check("R4 sweep low", lo, expLen(l));
        end
      end
    end

    // R2: drop enable during a high phase
    runPair(6, 4, fl, hi, lo);
    while (!pulseOut) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R2 off next cycle", int'(pulseOut), 0);
    cnt = 0;
    repeat (20) begin @(negedge clk); if (pulseOut) cnt++; end
    check("R2 stays low", cnt, 0);
    enable = 1'b1;
    measure(fl, hi, lo);
    check("R2 restart low phase", fl, 4);

    // R5 / R6: reserved code while running, then corrected
    runPair(3, 3, fl, hi, lo);
    while (!pulseOut) @(negedge clk);
    highCode = 4'd1;
    #1;
    check("R5 bad flag combinational", int'(badCode), 1);
    @(negedge clk);
    check("R5 held low", int'(pulseOut), 0);
    cnt = 0;
    repeat (20) begin @(negedge clk); if (pulseOut) cnt++; end
    check("R5 stays low", cnt, 0);
    highCode = 4'd3; lowCode = 4'd1;
    #1;
    check("R5 bad low field", int'(badCode), 1);
    @(negedge clk);
    highCode = 4'd7; lowCode = 4'd9;
    #1;
    check("R5 flag clears", int'(badCode), 0);
    measure(fl, hi, lo);
    check("R6 fresh low", fl, 9);
    check("R6 high after", hi, 7);

    // R7: change code mid-phase
    runPair(4, 6, fl, hi, lo);
    while (!pulseOut) @(negedge clk);
    highCode = 4'd10;
    hi = 0;
    while (pulseOut && hi < 40) begin hi++; @(negedge clk); end
    check("R7 current high keeps old len", hi, 4);
    lo = 0;
    while (!pulseOut && lo < 40) begin lo++; @(negedge clk); end
    check("R7 low len", lo, 6);
    hi = 0;
    while (pulseOut && hi < 40) begin hi++; @(negedge clk); end
    check("R7 next high uses new len", hi, 10);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule